// File: doc/BRIEF.md
# Fused Read-Modify-Write ALU for an 8-bit Accumulator Core

This block evaluates, in one step, the compound instructions of an 8-bit accumulator processor that chain a memory-side modification (shift, rotate, increment or decrement) into a register-side operation (OR, AND, XOR, add, subtract or compare). It also evaluates a group of immediate-operand hybrids whose carry and overflow rules differ from those of the plain instructions. The surrounding core supplies the operation code, the A and X registers, the stack pointer, the operand byte (read from memory or taken as an immediate) and the current N, V, Z and C flags. The core then pulses `start`.

One clock edge later the block presents its results and raises `done` for that cycle. The results are the byte to write back to memory, the new A, X and S values with a write enable each, and a complete new set of N, V, Z and C flags. Any flag that an operation does not define is passed through from its input. Decimal mode is not modelled, so all arithmetic is binary.

The controller is a two-state machine:
- `ST_IDLE` moves to `ST_DONE` when `start` is high and otherwise stays in `ST_IDLE`.
- `ST_DONE` moves back to `ST_DONE` when `start` is high again (back-to-back issue) and otherwise returns to `ST_IDLE`.
- `done` is high exactly while the machine is in `ST_DONE`.

Top module: `combo_alu`

## Requirements
- R1: A synchronous reset clears `done` and the four write enables, puts the controller in `ST_IDLE` and clears all output bytes and flags to 0.
- R2: Outputs, write enables and `done` update exactly one clock after a cycle with `start` high. After a cycle without `start`, `done` and every write enable are low and the flag outputs hold their values.
- R3: Op 0 (shift-left-OR) and op 2 (shift-right-XOR) shift the operand by one place with a 0 shifted in. They write the shifted byte to memory and set A to A OR it (op 0) or A XOR it (op 2). C takes the bit shifted out, N and Z follow the new A, and V passes through.
- R4: Op 1 (rotate-left-AND) rotates the operand left with the incoming C entering bit 0. It writes the rotated byte to memory and sets A to A AND it. C takes the old operand bit 7, N and Z follow A, and V passes through.
- R5: Op 3 (rotate-right-add) rotates the operand right with the incoming C entering bit 7 and writes the rotated byte to memory. It then sets A to A plus the rotated byte plus the old operand bit 0. C is the carry out of bit 7, V is the signed overflow of that sum, and N and Z follow A.
- R6: Op 4 (decrement-compare) writes the operand minus 1 to memory. It leaves A unwritten and sets C when A is at least that value (unsigned). N and Z come from A minus that value, and V passes through.
- R7: Op 5 (increment-subtract) writes the operand plus 1 to memory and sets A to A minus that value minus (1 − C). C is set when no borrow occurs, V is the signed overflow of the subtraction, and N and Z follow A.
- R8: Op 6 (AND with carry) sets A to A AND operand. C copies bit 7 of the result, N and Z follow A, and V passes through.
- R9: Op 7 (AND-rotate) forms T = A AND operand and sets A to T shifted right with the incoming C in bit 7. C copies T bit 7, and V is the signed overflow of T + operand with no carry in. N and Z follow A.
- R10: Op 8 (AND-subtract to X) sets X to (A AND X) minus operand, ignoring the incoming C. C is set when (A AND X) is at least the operand, N and Z follow X, V passes through, and A is not written.
- R11: Op 9 (load both) writes the operand to A and X and sets N and Z from it. Op 10 (store both) writes A AND X to memory and passes all four flags through unchanged.
- R12: Op 11 (stack load) writes operand AND S to A, X and S. N and Z follow that value, and C and V pass through.
- R13: Ops 12 to 15 raise `done` but assert no write enable and pass all four flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation on the presented inputs |
| op | input | 4 | Operation code (0 to 11 defined) |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current X register |
| s_in | input | 8 | Current stack pointer |
| operand | input | 8 | Memory or immediate operand byte |
| n_in | input | 1 | Incoming negative flag |
| v_in | input | 1 | Incoming overflow flag |
| z_in | input | 1 | Incoming zero flag |
| c_in | input | 1 | Incoming carry flag |
| mem_out | output | 8 | Byte to write back to memory |
| mem_we | output | 1 | Memory write-back enable |
| a_out | output | 8 | New accumulator value |
| a_we | output | 1 | Accumulator write enable |
| x_out | output | 8 | New X value |
| x_we | output | 1 | X write enable |
| s_out | output | 8 | New stack pointer value |
| s_we | output | 1 | Stack pointer write enable |
| n_out | output | 1 | New negative flag |
| v_out | output | 1 | New overflow flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |
| done | output | 1 | Result valid, one cycle after start |

## Verification
The assertions check on every cycle the timing contract:
- `done` follows `start` by exactly one edge;
- no write enable appears without `done`;
- the flags hold while idle;
- two per-operation invariants: the decrement-compare writes memory but never A, and the store-both operation leaves every flag as supplied.

The arithmetic content cannot be checked that way. The bench's sweeps over every operand byte, several accumulator values and both carry states are what show it: shifted-out carries, the rotate-through-carry paths, the overflow rules of the add, subtract and AND-rotate, and the borrow sense of the compares.

// File: rtl/combo_alu_pkg.sv
package combo_alu_pkg;

    typedef enum logic [3:0] {
        OP_SHL_OR   = 4'd0,
        OP_ROL_AND  = 4'd1,
        OP_SHR_XOR  = 4'd2,
        OP_ROR_ADC  = 4'd3,
        OP_DEC_CMP  = 4'd4,
        OP_INC_SBC  = 4'd5,
        OP_AND_C    = 4'd6,
        OP_AND_ROR  = 4'd7,
        OP_AX_SUB   = 4'd8,
        OP_LOAD_AX  = 4'd9,
        OP_STORE_AX = 4'd10,
        OP_LOAD_S   = 4'd11,
        OP_RSV12    = 4'd12,
        OP_RSV13    = 4'd13,
        OP_RSV14    = 4'd14,
        OP_RSV15    = 4'd15
    } op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;

endpackage

// File: rtl/combo_modify.sv
// Memory-side step: shift, rotate, increment or decrement of the operand.
module combo_modify
    import combo_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] opd,
    input  logic          c_in,
    output logic [DW-1:0] mod_byte,
    output logic          mod_carry
);
    localparam int MSB = DW - 1;

    always_comb begin
        mod_byte  = opd;
        mod_carry = c_in;
        unique case (op)
            OP_SHL_OR: begin
                mod_byte  = {opd[MSB-1:0], 1'b0};
                mod_carry = opd[MSB];
            end
            OP_ROL_AND: begin
                mod_byte  = {opd[MSB-1:0], c_in};
                mod_carry = opd[MSB];
            end
            OP_SHR_XOR: begin
                mod_byte  = {1'b0, opd[MSB:1]};
                mod_carry = opd[0];
            end
            OP_ROR_ADC: begin
                mod_byte  = {c_in, opd[MSB:1]};
                mod_carry = opd[0];
            end
            OP_DEC_CMP: mod_byte = opd - {{(DW-1){1'b0}}, 1'b1};
            OP_INC_SBC: mod_byte = opd + {{(DW-1){1'b0}}, 1'b1};
            default: begin
                mod_byte  = opd;
                mod_carry = c_in;
            end
        endcase
    end
endmodule

// File: rtl/combo_second.sv
// Register-side step: logic, add, subtract or compare, plus flag rules.
module combo_second
    import combo_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] s,
    input  logic [DW-1:0] opd,
    input  logic [DW-1:0] mod_byte,
    input  logic          mod_carry,
    input  flags_t        f_in,
    output logic [DW-1:0] res,
    output logic [DW-1:0] mem_d,
    output logic          mem_we,
    output logic          a_we,
    output logic          x_we,
    output logic          s_we,
    output flags_t        f_out
);
    localparam int MSB = DW - 1;
    localparam int EW  = DW + 1;

    logic [EW-1:0] add_sum;
    logic [EW-1:0] sbc_diff;
    logic [EW-1:0] cmp_diff;
    logic [EW-1:0] axs_diff;
    logic [EW-1:0] arr_sum;
    logic [DW-1:0] and_ao;
    logic [DW-1:0] and_ax;
    logic          set_nz;

    always_comb begin
        and_ao   = a & opd;
        and_ax   = a & x;
        add_sum  = {1'b0, a} + {1'b0, mod_byte} + {{DW{1'b0}}, mod_carry};
        sbc_diff = {1'b0, a} - {1'b0, mod_byte} - {{DW{1'b0}}, ~f_in.c};
        cmp_diff = {1'b0, a} - {1'b0, mod_byte};
        axs_diff = {1'b0, and_ax} - {1'b0, opd};
        arr_sum  = {1'b0, and_ao} + {1'b0, opd};
    end

    always_comb begin
        res    = '0;
        mem_d  = mod_byte;
        mem_we = 1'b0;
        a_we   = 1'b0;
        x_we   = 1'b0;
        s_we   = 1'b0;
        set_nz = 1'b0;
        f_out  = f_in;
        unique case (op)
            OP_SHL_OR: begin
                res = a | mod_byte; a_we = 1'b1; mem_we = 1'b1;
                set_nz = 1'b1; f_out.c = mod_carry;
            end
            OP_ROL_AND: begin
                res = a & mod_byte; a_we = 1'b1; mem_we = 1'b1;
                set_nz = 1'b1; f_out.c = mod_carry;
            end
            OP_SHR_XOR: begin
                res = a ^ mod_byte; a_we = 1'b1; mem_we = 1'b1;
                set_nz = 1'b1; f_out.c = mod_carry;
            end
            OP_ROR_ADC: begin
                res = add_sum[MSB:0]; a_we = 1'b1; mem_we = 1'b1;
                set_nz = 1'b1; f_out.c = add_sum[DW];
                f_out.v = (a[MSB] == mod_byte[MSB]) && (add_sum[MSB] != a[MSB]);
            end
            OP_DEC_CMP: begin
                res = cmp_diff[MSB:0]; mem_we = 1'b1;
                set_nz = 1'b1; f_out.c = ~cmp_diff[DW];
            end
            OP_INC_SBC: begin
                res = sbc_diff[MSB:0]; a_we = 1'b1; mem_we = 1'b1;
                set_nz = 1'b1; f_out.c = ~sbc_diff[DW];
                f_out.v = (a[MSB] != mod_byte[MSB]) && (sbc_diff[MSB] != a[MSB]);
            end
            OP_AND_C: begin
                res = and_ao; a_we = 1'b1;
                set_nz = 1'b1; f_out.c = and_ao[MSB];
            end
            OP_AND_ROR: begin
                res = {f_in.c, and_ao[MSB:1]}; a_we = 1'b1;
                set_nz = 1'b1; f_out.c = and_ao[MSB];
                f_out.v = (and_ao[MSB] == opd[MSB]) && (arr_sum[MSB] != and_ao[MSB]);
            end
            OP_AX_SUB: begin
                res = axs_diff[MSB:0]; x_we = 1'b1;
                set_nz = 1'b1; f_out.c = ~axs_diff[DW];
            end
            OP_LOAD_AX: begin
                res = opd; a_we = 1'b1; x_we = 1'b1; set_nz = 1'b1;
            end
            OP_STORE_AX: begin
                mem_d = and_ax; mem_we = 1'b1;
            end
            OP_LOAD_S: begin
                res = opd & s; a_we = 1'b1; x_we = 1'b1; s_we = 1'b1;
                set_nz = 1'b1;
            end
            default: begin
                res = '0;
            end
        endcase
        if (set_nz) begin
            f_out.n = res[MSB];
            f_out.z = (res == '0);
        end
    end
endmodule

// File: rtl/combo_alu.sv
module combo_alu
    import combo_alu_pkg::*;
#(
    parameter int DW = 8,
    parameter int OPW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] s_in,
    input  logic [DW-1:0] operand,
    input  logic          n_in,
    input  logic          v_in,
    input  logic          z_in,
    input  logic          c_in,
    output logic [DW-1:0] mem_out,
    output logic          mem_we,
    output logic [DW-1:0] a_out,
    output logic          a_we,
    output logic [DW-1:0] x_out,
    output logic          x_we,
    output logic [DW-1:0] s_out,
    output logic          s_we,
    output logic          n_out,
    output logic          v_out,
    output logic          z_out,
    output logic          c_out,
    output logic          done
);
    state_e        state_q, state_d;
    op_e           op_sel;
    flags_t        f_in, f_new;
    logic [DW-1:0] mod_byte, res, mem_d;
    logic          mod_carry, mem_we_d, a_we_d, x_we_d, s_we_d;

    assign op_sel = op_e'(op[3:0]);
    assign f_in   = '{n: n_in, v: v_in, z: z_in, c: c_in};

    combo_modify #(.DW(DW)) u_modify (
        .op        (op_sel),
        .opd       (operand),
        .c_in      (c_in),
        .mod_byte  (mod_byte),
        .mod_carry (mod_carry)
    );

    combo_second #(.DW(DW)) u_second (
        .op        (op_sel),
        .a         (a_in),
        .x         (x_in),
        .s         (s_in),
        .opd       (operand),
        .mod_byte  (mod_byte),
        .mod_carry (mod_carry),
        .f_in      (f_in),
        .res       (res),
        .mem_d     (mem_d),
        .mem_we    (mem_we_d),
        .a_we      (a_we_d),
        .x_we      (x_we_d),
        .s_we      (s_we_d),
        .f_out     (f_new)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign done = (state_q == ST_DONE);

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_out <= '0; a_out <= '0; x_out <= '0; s_out <= '0;
            mem_we  <= 1'b0; a_we <= 1'b0; x_we <= 1'b0; s_we <= 1'b0;
            n_out   <= 1'b0; v_out <= 1'b0; z_out <= 1'b0; c_out <= 1'b0;
        end else if (start) begin
            mem_out <= mem_d; a_out <= res; x_out <= res; s_out <= res;
            mem_we  <= mem_we_d; a_we <= a_we_d; x_we <= x_we_d; s_we <= s_we_d;
            n_out   <= f_new.n; v_out <= f_new.v; z_out <= f_new.z; c_out <= f_new.c;
        end else begin
            mem_we <= 1'b0; a_we <= 1'b0; x_we <= 1'b0; s_we <= 1'b0;
        end
    end

    assert_done_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!done && !a_we && !x_we && !s_we && !mem_we));
    assert_flags_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable({n_out, v_out, z_out, c_out}));
    assert_we_needs_done_R1: assert property (@(posedge clk) disable iff (rst)
        (a_we || x_we || s_we || mem_we) |-> done);
    assert_cmp_no_a_R6: assert property (@(posedge clk) disable iff (rst)
        (start && op == 4'd4) |=> (mem_we && !a_we));
    assert_store_flags_R11: assert property (@(posedge clk) disable iff (rst)
        (start && op == 4'd10) |=>
        ({n_out, v_out, z_out, c_out} == $past({n_in, v_in, z_in, c_in})));
endmodule

// File: tb/combo_alu_tb.sv
module combo_alu_tb;
    logic       clk = 1'b0;
    logic       rst, start;
    logic [3:0] op;
    logic [7:0] a_in, x_in, s_in, operand;
    logic       n_in, v_in, z_in, c_in;
    logic [7:0] mem_out, a_out, x_out, s_out;
    logic       mem_we, a_we, x_we, s_we, n_out, v_out, z_out, c_out, done;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    combo_alu u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .a_in(a_in), .x_in(x_in), .s_in(s_in), .operand(operand),
        .n_in(n_in), .v_in(v_in), .z_in(z_in), .c_in(c_in),
        .mem_out(mem_out), .mem_we(mem_we), .a_out(a_out), .a_we(a_we),
        .x_out(x_out), .x_we(x_we), .s_out(s_out), .s_we(s_we),
        .n_out(n_out), .v_out(v_out), .z_out(z_out), .c_out(c_out),
        .done(done)
    );

    function automatic string req_of(input int code);
        case (code)
            0, 2: return "R3";
            1: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            7: return "R9";
            8: return "R10";
            9, 10: return "R11";
            11: return "R12";
            default: return "R13";
        endcase
    endfunction

    // Independent reference built from the requirement text.
    task automatic check_op(input int code);
        logic [7:0] a, x, s, d, m, r, t, em;
        logic       n, v, z, c, ma, xa, sa, mw;
        logic [8:0] w;
        logic       nz;
        a = a_in; x = x_in; s = s_in; d = operand;
        n = n_in; v = v_in; z = z_in; c = c_in;
        ma = 0; xa = 0; sa = 0; mw = 0; nz = 0; r = 0; em = 0;
        case (code)
            0: begin m = d << 1; c = d[7]; r = a | m; em = m; mw = 1; ma = 1; nz = 1; end
            2: begin m = d >> 1; c = d[0]; r = a ^ m; em = m; mw = 1; ma = 1; nz = 1; end
            1: begin m = {d[6:0], c_in}; c = d[7]; r = a & m; em = m; mw = 1; ma = 1; nz = 1; end
            3: begin
                m = {c_in, d[7:1]}; w = a + m + d[0]; r = w[7:0]; c = w[8];
                v = (a[7] == m[7]) && (r[7] != a[7]); em = m; mw = 1; ma = 1; nz = 1;
            end
            4: begin m = d - 1; em = m; mw = 1; c = (a >= m); r = a - m; nz = 1; end
            5: begin
                m = d + 1; em = m; mw = 1; ma = 1; nz = 1;
                r = a - m - (c_in ? 8'd0 : 8'd1);
                c = (int'(a) - int'(m) - (c_in ? 0 : 1)) >= 0;
                v = (a[7] != m[7]) && (r[7] != a[7]);
            end
            6: begin r = a & d; c = r[7]; ma = 1; nz = 1; end
            7: begin
                t = a & d; r = {c_in, t[7:1]}; c = t[7]; ma = 1; nz = 1;
                w = t + d; v = (t[7] == d[7]) && (w[7] != t[7]);
            end
            8: begin t = a & x; r = t - d; c = (t >= d); xa = 1; nz = 1; end
            9: begin r = d; ma = 1; xa = 1; nz = 1; end
            10: begin em = a & x; mw = 1; end
            11: begin r = d & s; ma = 1; xa = 1; sa = 1; nz = 1; end
            default: ;
        endcase
        if (nz) begin n = r[7]; z = (r == 0); end
        total++;
        if (done !== 1'b1 || a_we !== ma || x_we !== xa || s_we !== sa || mem_we !== mw ||
            (ma && a_out !== r) || (xa && x_out !== r) || (sa && s_out !== r) ||
            (mw && mem_out !== em) || {n_out, v_out, z_out, c_out} !== {n, v, z, c}) begin
            bad++;
            $display("FAIL %s op=%0d a=%h x=%h s=%h d=%h c=%b: actual we=%b%b%b%b a=%h x=%h s=%h m=%h nvzc=%b%b%b%b done=%b expected we=%b%b%b%b a=%h x=%h s=%h m=%h nvzc=%b%b%b%b",
                req_of(code), code, a, x, s, d, c_in, a_we, x_we, s_we, mem_we,
                a_out, x_out, s_out, mem_out, n_out, v_out, z_out, c_out, done,
                ma, xa, sa, mw, r, r, r, em, n, v, z, c);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] atab [4];
        logic [3:0] held;
        atab[0] = 8'h00; atab[1] = 8'h7F; atab[2] = 8'h80; atab[3] = 8'hC5;
        rst = 1; start = 0; op = 0; a_in = 0; x_in = 0; s_in = 0; operand = 0;
        n_in = 0; v_in = 0; z_in = 0; c_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        total++;
        if (done !== 0 || a_we !== 0 || x_we !== 0 || s_we !== 0 || mem_we !== 0 ||
            {n_out, v_out, z_out, c_out} !== 4'b0 || a_out !== 0 || mem_out !== 0) begin
            bad++;
            $display("FAIL R1 reset: done=%b we=%b%b%b%b nvzc=%b%b%b%b expected all 0",
                done, a_we, x_we, s_we, mem_we, n_out, v_out, z_out, c_out);
        end
        // Sweep: every op, four accumulators, every operand byte, both carries
        for (int o = 0; o < 16; o++) begin
            for (int ai = 0; ai < 4; ai++) begin
                for (int d = 0; d < 256; d++) begin
                    op = 4'(o); a_in = atab[ai]; operand = 8'(d);
                    x_in = 8'(d) ^ 8'(ai * 8'h5A) ^ 8'h3C;
                    s_in = ~8'(d) + 8'(ai * 3);
                    c_in = d[0] ^ ai[0] ^ d[4];
                    v_in = d[1]; n_in = d[2]; z_in = d[3];
                    start = 1;
                    @(negedge clk);
                    check_op(o);
                end
            end
        end
        // R2: idle cycle after a result drops done and enables, flags hold
        op = 4'd9; operand = 8'h80; start = 1;
        @(negedge clk);
        check_op(9);
        held = {n_out, v_out, z_out, c_out};
        start = 0; n_in = ~n_in; c_in = ~c_in; v_in = ~v_in; z_in = ~z_in;
        @(negedge clk);
        total++;
        if (done !== 0 || a_we !== 0 || x_we !== 0 || s_we !== 0 || mem_we !== 0 ||
            {n_out, v_out, z_out, c_out} !== held) begin
            bad++;
            $display("FAIL R2 idle: done=%b we=%b%b%b%b nvzc=%b%b%b%b expected 0 0000 %b",
                done, a_we, x_we, s_we, mem_we, n_out, v_out, z_out, c_out, held);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule